// File: doc/BRIEF.md
# Display Controller Register and Interrupt Unit

This block is the software-visible face of a raster display controller. A simple request bus reads and writes four timing words, the frame base addresses for the upper and lower panels, a control word and the interrupt mask. Two word-indexed windows hold the colour palette and the cursor image. From the stored timing words the block works out the active picture width and height. From the control word it derives the FIFO watermark and a one-cycle start pulse for the pixel fetch engine.

The fetch engine reports events through single-cycle set strobes, one per interrupt source: FIFO underrun, base-address update, vertical compare and bus-master error. Each strobe sets a raw status bit. The masked view is the AND of the mask and the raw bits, and a level interrupt output is high while any masked bit is set. Software clears raw bits by writing ones to a clear register. Illegal accesses do not halt anything. An unmapped offset, a write to a read-only register, a read of the write-only clear register, or a mask write that enables vertical compare each return an error flag with the response.

Every request is answered exactly one cycle later with `rsp_valid`. A write takes effect on the same clock edge that registers its response.

Top module: `dispctl_regs`

## Requirements
- R1: After reset every register and window word reads 0, `irq` is 0, `fetch_start` is 0, `fifo_wmark` is 4, `act_width` is 16 and `act_height` is 1.
- R2: `act_width` equals 16 x (F + 1), where F is bits [7:2] of timing word 0 (offset 0x000). It follows the stored word from the edge that writes it.
- R3: `act_height` equals L + 1, where L is bits [9:0] of timing word 1 (offset 0x004). It follows the stored word from the edge that writes it.
- R4: Timing words 0..3 (0x000, 0x004, 0x008, 0x00C), upper base (0x010), lower base (0x014) and control (0x018) read back the full 32-bit value written. The mask (0x01C) reads back its low 4 bits. Interrupt bit order is 0 underrun, 1 base update, 2 vertical compare, 3 bus-master error.
- R5: The masked status (0x024) always equals mask AND raw status (0x020). `irq` is 1 exactly when that AND is non-zero. A set strobe or mask write shows on `irq` from the edge that samples it.
- R6: Writing the clear register (0x028) clears every raw bit that is 1 in bits [3:0] of the data. A read of 0x028 returns data 0 with the error flag.
- R7: When a set strobe and a clear write target the same raw bit in one cycle, the bit ends up set.
- R8: Raw status, masked status and the two current-address registers (0x02C, 0x030) are read-only. A write to any of them returns the error flag and changes nothing. A read of a current-address register returns `fetch_addr`.
- R9: Palette words live at 0x200..0x3FC and cursor image words at 0x800..0xBFC. The word index is (offset - window base) >> 2, and every word holds its own value.
- R10: A request to any other offset, or to an offset with bits [1:0] non-zero, returns data 0 with the error flag, and a write there has no effect.
- R11: A control write that sets bit 1 (power) while it is 0 produces a one-cycle `fetch_start` pulse. No other control write produces one. `fifo_wmark` is 8 when control bit 2 is 1 and 4 otherwise. Control bit 0 is display enable.
- R12: A mask write with bit 2 (vertical compare) set returns the error flag. The value is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Access error |
| irq_set | input | 4 | Set strobes from the fetch engine |
| fetch_addr | input | 32 | Current fetch address from the fetch engine |
| irq | output | 1 | Level interrupt |
| act_width | output | 11 | Active width in pixels |
| act_height | output | 11 | Active height in lines |
| fifo_wmark | output | 4 | FIFO watermark |
| fetch_start | output | 1 | Frame fetch start pulse |

## Verification
A response is registered on the edge that samples its request. The driver pushes the expected word and error flag when it raises `bus_req`, and the monitor pops and compares at the falling edge that follows the next rising edge. Register side effects (`act_width`, `act_height`, `fifo_wmark`, `fetch_start`, `irq`) also appear after that one edge, so they are sampled at the same falling edge the access task returns on. `fetch_start` is sampled once more one cycle later to confirm it lasts a single cycle. Set strobes are driven for one cycle, and `irq` is read at the next falling edge.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int IRQ_W  = 4;
  localparam int PPL_W  = 6;
  localparam int LPP_W  = 10;
  localparam int WID_W  = PPL_W + 5;
  localparam int HGT_W  = LPP_W + 1;
  localparam int WM_W   = 4;

  // interrupt bit positions
  localparam int IB_UFLOW = 0;
  localparam int IB_BASE  = 1;
  localparam int IB_VCMP  = 2;
  localparam int IB_BERR  = 3;

  // control bits
  localparam int CB_EN  = 0;
  localparam int CB_PWR = 1;
  localparam int CB_WM  = 2;

  localparam logic [WM_W-1:0] WM_HI = 4'd8;
  localparam logic [WM_W-1:0] WM_LO = 4'd4;

  localparam logic [ADDR_W-1:0] OFS_T0    = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_T1    = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_T2    = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_T3    = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_UBASE = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_LBASE = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h01C;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_MSKD  = 12'h024;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h028;
  localparam logic [ADDR_W-1:0] OFS_UCUR  = 12'h02C;
  localparam logic [ADDR_W-1:0] OFS_LCUR  = 12'h030;

  localparam logic [ADDR_W-1:0] PAL_BASE = 12'h200;
  localparam logic [ADDR_W-1:0] PAL_LAST = 12'h3FC;
  localparam logic [ADDR_W-1:0] CUR_BASE = 12'h800;
  localparam logic [ADDR_W-1:0] CUR_LAST = 12'hBFC;
  localparam int PAL_WORDS = int'((PAL_LAST - PAL_BASE) >> 2) + 1;
  localparam int CUR_WORDS = int'((CUR_LAST - CUR_BASE) >> 2) + 1;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_T0, SEL_T1, SEL_T2, SEL_T3, SEL_UBASE, SEL_LBASE,
    SEL_CTRL, SEL_MASK, SEL_RAW, SEL_MSKD, SEL_CLR, SEL_UCUR, SEL_LCUR,
    SEL_PAL, SEL_CUR
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    s = SEL_NONE;
    if (a[1:0] == 2'b00) begin
      if (a >= PAL_BASE && a <= PAL_LAST)      s = SEL_PAL;
      else if (a >= CUR_BASE && a <= CUR_LAST) s = SEL_CUR;
      else begin
        case (a)
          OFS_T0:    s = SEL_T0;
          OFS_T1:    s = SEL_T1;
          OFS_T2:    s = SEL_T2;
          OFS_T3:    s = SEL_T3;
          OFS_UBASE: s = SEL_UBASE;
          OFS_LBASE: s = SEL_LBASE;
          OFS_CTRL:  s = SEL_CTRL;
          OFS_MASK:  s = SEL_MASK;
          OFS_RAW:   s = SEL_RAW;
          OFS_MSKD:  s = SEL_MSKD;
          OFS_CLR:   s = SEL_CLR;
          OFS_UCUR:  s = SEL_UCUR;
          OFS_LCUR:  s = SEL_LCUR;
          default:   s = SEL_NONE;
        endcase
      end
    end
    return s;
  endfunction

  // word offset inside a window
  function automatic logic [ADDR_W-3:0] word_off(input logic [ADDR_W-1:0] a,
                                                  input logic [ADDR_W-1:0] base);
    logic [ADDR_W-1:0] d;
    d = a - base;
    return d[ADDR_W-1:2];
  endfunction

  function automatic logic [WID_W-1:0] px_width(input logic [PPL_W-1:0] f);
    return {1'b0, f, 4'b0000} + WID_W'(16);
  endfunction

  function automatic logic [HGT_W-1:0] px_height(input logic [LPP_W-1:0] f);
    return {1'b0, f} + HGT_W'(1);
  endfunction

endpackage

// File: rtl/dispctl_word_store.sv
module dispctl_word_store #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 10,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  idx;

  assign idx   = off[IDX_W-1:0];
  assign rdata = mem[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  // a write must land inside the window
  AST_WIN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> ((off >> IDX_W) == '0)); // R9

endmodule

// File: rtl/dispctl_irq.sv
module dispctl_irq #(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_we,
  input  logic [IRQ_W-1:0] mask_wdata,
  input  logic             clr_we,
  input  logic [IRQ_W-1:0] clr_bits,
  input  logic [IRQ_W-1:0] set_req,
  output logic [IRQ_W-1:0] mask_q,
  output logic [IRQ_W-1:0] raw_q,
  output logic [IRQ_W-1:0] masked_q,
  output logic             irq
);

  logic [IRQ_W-1:0] raw_d;
  logic [IRQ_W-1:0] mask_d;
  logic [IRQ_W-1:0] clr_hit;

  assign mask_d = mask_we ? mask_wdata : mask_q;

  for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
    assign clr_hit[i] = clr_we & clr_bits[i];
    // set wins over clear
    assign raw_d[i]   = set_req[i] | (raw_q[i] & ~clr_hit[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      raw_q    <= '0;
      masked_q <= '0;
      irq      <= 1'b0;
    end else begin
      mask_q   <= mask_d;
      raw_q    <= raw_d;
      masked_q <= mask_d & raw_d;
      irq      <= |(mask_d & raw_d);
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_req) |=> ((raw_q & $past(set_req)) == $past(set_req))); // R7

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && ((clr_bits & ~set_req) != '0)) |=>
      ((raw_q & $past(clr_bits & ~set_req)) == '0)); // R6

  AST_MASKED_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    masked_q == (mask_q & raw_q)); // R5

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (masked_q != '0)); // R5

endmodule

// File: rtl/dispctl_geom.sv
module dispctl_geom
  import dispctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PPL_W-1:0] ppl_field,
  input  logic [LPP_W-1:0] lpp_field,
  input  logic             pwr_cur,
  input  logic             wm_sel,
  input  logic             ctrl_we,
  input  logic             pwr_new,
  output logic [WID_W-1:0] act_width,
  output logic [HGT_W-1:0] act_height,
  output logic [WM_W-1:0]  fifo_wmark,
  output logic             fetch_start
);

  logic pwr_rise;

  assign pwr_rise   = ctrl_we & pwr_new & ~pwr_cur;
  assign act_width  = px_width(ppl_field);
  assign act_height = px_height(lpp_field);
  assign fifo_wmark = wm_sel ? WM_HI : WM_LO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fetch_start <= 1'b0;
    else        fetch_start <= pwr_rise;
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |=> !fetch_start); // R11

  AST_START_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |-> pwr_cur); // R11

endmodule

// File: rtl/dispctl_regs.sv
module dispctl_regs
  import dispctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  input  logic [IRQ_W-1:0]  irq_set,
  input  logic [DATA_W-1:0] fetch_addr,
  output logic              irq,
  output logic [WID_W-1:0]  act_width,
  output logic [HGT_W-1:0]  act_height,
  output logic [WM_W-1:0]   fifo_wmark,
  output logic              fetch_start
);

  localparam int OFF_W = ADDR_W - 2;
  localparam int PAD_W = DATA_W - IRQ_W;

  reg_sel_e          sel;
  logic              wr_fire, rd_fire;
  logic [DATA_W-1:0] t0_q, t1_q, t2_q, t3_q, ubase_q, lbase_q, ctrl_q;
  logic [IRQ_W-1:0]  mask_q, raw_q, masked_q;
  logic [OFF_W-1:0]  pal_off, cur_off;
  logic [DATA_W-1:0] pal_rdata, cur_rdata;
  logic              pal_we, cur_we;
  logic [DATA_W-1:0] rd_mux;
  logic              err_d;
  logic              ro_write;

  assign sel     = decode_sel(bus_addr);
  assign wr_fire = bus_req & bus_wr;
  assign rd_fire = bus_req & ~bus_wr;
  assign pal_off = word_off(bus_addr, PAL_BASE);
  assign cur_off = word_off(bus_addr, CUR_BASE);
  assign pal_we  = wr_fire && sel == SEL_PAL;
  assign cur_we  = wr_fire && sel == SEL_CUR;
  assign ro_write = wr_fire && (sel == SEL_RAW || sel == SEL_MSKD ||
                                sel == SEL_UCUR || sel == SEL_LCUR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t0_q    <= '0;
      t1_q    <= '0;
      t2_q    <= '0;
      t3_q    <= '0;
      ubase_q <= '0;
      lbase_q <= '0;
      ctrl_q  <= '0;
    end else if (wr_fire) begin
      case (sel)
        SEL_T0:    t0_q    <= bus_wdata;
        SEL_T1:    t1_q    <= bus_wdata;
        SEL_T2:    t2_q    <= bus_wdata;
        SEL_T3:    t3_q    <= bus_wdata;
        SEL_UBASE: ubase_q <= bus_wdata;
        SEL_LBASE: lbase_q <= bus_wdata;
        SEL_CTRL:  ctrl_q  <= bus_wdata;
        default:   ;
      endcase
    end
  end

  dispctl_irq #(.IRQ_W(IRQ_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_we    (wr_fire && sel == SEL_MASK),
    .mask_wdata (bus_wdata[IRQ_W-1:0]),
    .clr_we     (wr_fire && sel == SEL_CLR),
    .clr_bits   (bus_wdata[IRQ_W-1:0]),
    .set_req    (irq_set),
    .mask_q     (mask_q),
    .raw_q      (raw_q),
    .masked_q   (masked_q),
    .irq        (irq)
  );

  dispctl_geom u_geom (
    .clk         (clk),
    .rst_n       (rst_n),
    .ppl_field   (t0_q[PPL_W+1:2]),
    .lpp_field   (t1_q[LPP_W-1:0]),
    .pwr_cur     (ctrl_q[CB_PWR]),
    .wm_sel      (ctrl_q[CB_WM]),
    .ctrl_we     (wr_fire && sel == SEL_CTRL),
    .pwr_new     (bus_wdata[CB_PWR]),
    .act_width   (act_width),
    .act_height  (act_height),
    .fifo_wmark  (fifo_wmark),
    .fetch_start (fetch_start)
  );

  dispctl_word_store #(.DEPTH(PAL_WORDS), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_pal (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (pal_we),
    .off   (pal_off),
    .wdata (bus_wdata),
    .rdata (pal_rdata)
  );

  dispctl_word_store #(.DEPTH(CUR_WORDS), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_cur (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cur_we),
    .off   (cur_off),
    .wdata (bus_wdata),
    .rdata (cur_rdata)
  );

  always_comb begin
    case (sel)
      SEL_T0:    rd_mux = t0_q;
      SEL_T1:    rd_mux = t1_q;
      SEL_T2:    rd_mux = t2_q;
      SEL_T3:    rd_mux = t3_q;
      SEL_UBASE: rd_mux = ubase_q;
      SEL_LBASE: rd_mux = lbase_q;
      SEL_CTRL:  rd_mux = ctrl_q;
      SEL_MASK:  rd_mux = {{PAD_W{1'b0}}, mask_q};
      SEL_RAW:   rd_mux = {{PAD_W{1'b0}}, raw_q};
      SEL_MSKD:  rd_mux = {{PAD_W{1'b0}}, masked_q};
      SEL_UCUR:  rd_mux = fetch_addr;
      SEL_LCUR:  rd_mux = fetch_addr;
      SEL_PAL:   rd_mux = pal_rdata;
      SEL_CUR:   rd_mux = cur_rdata;
      default:   rd_mux = '0;
    endcase
  end

  always_comb begin
    err_d = 1'b0;
    case (sel)
      SEL_NONE: err_d = 1'b1;
      SEL_RAW, SEL_MSKD, SEL_UCUR, SEL_LCUR: err_d = bus_wr;
      SEL_CLR:  err_d = ~bus_wr;
      SEL_MASK: err_d = bus_wr & bus_wdata[IB_VCMP];
      default:  err_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= bus_req;
      rsp_rdata <= (rd_fire && !err_d) ? rd_mux : '0;
      rsp_err   <= bus_req & err_d;
    end
  end

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> rsp_valid); // R4

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && sel == SEL_NONE) |=> (rsp_err && rsp_rdata == '0)); // R10

  AST_RO_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ro_write |=> rsp_err); // R8

  AST_RO_RAW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (ro_write && irq_set == '0) |=> $stable(raw_q)); // R8

  AST_VCMP_MASK_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && sel == SEL_MASK && bus_wdata[IB_VCMP]) |=> rsp_err); // R12

  AST_CLR_READ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && sel == SEL_CLR) |=> (rsp_err && rsp_rdata == '0)); // R6

endmodule

// File: tb/dispctl_regs_bench.sv
`timescale 1ns/100ps
module dispctl_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  irq_set = '0;
  logic [31:0] fetch_addr = 32'h1234_5678;
  logic        rsp_valid, rsp_err, irq, fetch_start;
  logic [31:0] rsp_rdata;
  logic [10:0] act_width, act_height;
  logic [3:0]  fifo_wmark;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  dispctl_regs u_dispctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq_set(irq_set),
    .fetch_addr(fetch_addr), .irq(irq), .act_width(act_width),
    .act_height(act_height), .fifo_wmark(fifo_wmark), .fetch_start(fetch_start)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL scoreboard: actual unexpected response expected none");
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.req, " data"}, rsp_rdata, e.data);
        chk({e.req, " err"}, {31'b0, rsp_err}, {31'b0, e.err});
      end
    end
  end

  // driver: one access, returns at the falling edge where the response is valid
  task automatic acc(input logic wr, input logic [11:0] a, input logic [31:0] d,
                     input logic [31:0] xd, input logic xe, input string req,
                     input logic [3:0] setv = 4'b0);
    exp_t e;
    @(negedge clk);
    bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d; irq_set = setv;
    e.data = wr ? 32'h0 : xd; e.err = xe; e.req = req;
    sb.push_back(e);
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0; irq_set = 4'b0;
  endtask

  task automatic pulse(input logic [3:0] v);
    @(negedge clk); irq_set = v;
    @(negedge clk); irq_set = 4'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 start", {31'b0, fetch_start}, 0);
    chk("R1 wmark", {28'b0, fifo_wmark}, 4);
    chk("R1 width", {21'b0, act_width}, 16);
    chk("R1 height", {21'b0, act_height}, 1);
    acc(0, 12'h000, 0, 0, 0, "R1 t0");
    acc(0, 12'h018, 0, 0, 0, "R1 ctrl");
    acc(0, 12'h01C, 0, 0, 0, "R1 mask");
    acc(0, 12'h020, 0, 0, 0, "R1 raw");
    acc(0, 12'h3FC, 0, 0, 0, "R1 pal");

    // R2 width
    acc(1, 12'h000, 32'h0000_003C, 0, 0, "R2 wr");
    chk("R2 width 256", {21'b0, act_width}, 256);
    acc(1, 12'h000, 32'hFFFF_FFFF, 0, 0, "R2 wr");
    chk("R2 width 1024", {21'b0, act_width}, 1024);
    acc(0, 12'h000, 0, 32'hFFFF_FFFF, 0, "R4 t0");
    // R3 height
    acc(1, 12'h004, 32'hABCD_E0EF, 0, 0, "R3 wr");
    chk("R3 height", {21'b0, act_height}, 240);
    acc(0, 12'h004, 0, 32'hABCD_E0EF, 0, "R4 t1");
    // R4 readback
    acc(1, 12'h008, 32'h1111_2222, 0, 0, "R4 wr");
    acc(1, 12'h00C, 32'h3333_4444, 0, 0, "R4 wr");
    acc(1, 12'h010, 32'h8000_1000, 0, 0, "R4 wr");
    acc(1, 12'h014, 32'h9000_2000, 0, 0, "R4 wr");
    acc(0, 12'h008, 0, 32'h1111_2222, 0, "R4 t2");
    acc(0, 12'h00C, 0, 32'h3333_4444, 0, "R4 t3");
    acc(0, 12'h010, 0, 32'h8000_1000, 0, "R4 ubase");
    acc(0, 12'h014, 0, 32'h9000_2000, 0, "R4 lbase");

    // R11 power edge and watermark
    acc(1, 12'h018, 32'h0000_0006, 0, 0, "R11 wr");
    chk("R11 start pulse", {31'b0, fetch_start}, 1);
    chk("R11 wmark 8", {28'b0, fifo_wmark}, 8);
    @(negedge clk);
    chk("R11 pulse ends", {31'b0, fetch_start}, 0);
    acc(1, 12'h018, 32'h0000_0007, 0, 0, "R11 wr");
    chk("R11 no repeat", {31'b0, fetch_start}, 0);
    acc(0, 12'h018, 0, 32'h0000_0007, 0, "R4 ctrl");
    acc(1, 12'h018, 32'h0000_0000, 0, 0, "R11 wr");
    chk("R11 wmark 4", {28'b0, fifo_wmark}, 4);
    chk("R11 power off no pulse", {31'b0, fetch_start}, 0);
    acc(1, 12'h018, 32'h0000_0002, 0, 0, "R11 wr");
    chk("R11 second start", {31'b0, fetch_start}, 1);

    // R5 mask and masked view
    acc(1, 12'h01C, 32'hFFFF_FFFB, 0, 0, "R4 mask wr");
    acc(0, 12'h01C, 0, 32'h0000_000B, 0, "R4 mask");
    chk("R5 irq idle", {31'b0, irq}, 0);
    pulse(4'b0010);
    chk("R5 irq up", {31'b0, irq}, 1);
    pulse(4'b0100);
    acc(0, 12'h020, 0, 32'h6, 0, "R5 raw");
    acc(0, 12'h024, 0, 32'h2, 0, "R5 masked");
    // R6 clear
    acc(1, 12'h028, 32'h0000_0002, 0, 0, "R6 wr");
    chk("R6 irq down", {31'b0, irq}, 0);
    acc(0, 12'h020, 0, 32'h4, 0, "R6 raw");
    acc(0, 12'h024, 0, 32'h0, 0, "R6 masked");
    acc(0, 12'h028, 0, 32'h0, 1, "R6 clr read");
    // R7 set beats clear
    acc(1, 12'h028, 32'h0000_0001, 0, 0, "R7 wr", 4'b0001);
    chk("R7 irq", {31'b0, irq}, 1);
    acc(0, 12'h020, 0, 32'h5, 0, "R7 raw");

    // R8 read-only
    acc(1, 12'h020, 32'h0000_000F, 0, 1, "R8 raw wr");
    acc(1, 12'h024, 32'h0000_000F, 0, 1, "R8 mskd wr");
    acc(1, 12'h02C, 32'h0000_000F, 0, 1, "R8 ucur wr");
    acc(1, 12'h030, 32'h0000_000F, 0, 1, "R8 lcur wr");
    acc(0, 12'h020, 0, 32'h5, 0, "R8 raw kept");
    acc(0, 12'h024, 0, 32'h1, 0, "R8 mskd kept");
    acc(0, 12'h02C, 0, 32'h1234_5678, 0, "R8 ucur");
    fetch_addr = 32'hCAFE_0040;
    acc(0, 12'h030, 0, 32'hCAFE_0040, 0, "R8 lcur");

    // R12 vertical compare mask
    acc(1, 12'h01C, 32'h0000_0004, 0, 1, "R12 wr");
    acc(0, 12'h01C, 0, 32'h4, 0, "R12 stored");
    chk("R5 irq on vcmp", {31'b0, irq}, 1);
    acc(0, 12'h024, 0, 32'h4, 0, "R5 masked vcmp");
    acc(1, 12'h01C, 32'h0, 0, 0, "R5 wr");
    chk("R5 irq masked off", {31'b0, irq}, 0);

    // R9 windows
    acc(1, 12'h200, 32'hA5A5_0001, 0, 0, "R9 wr");
    acc(1, 12'h204, 32'hA5A5_0002, 0, 0, "R9 wr");
    acc(1, 12'h3FC, 32'hA5A5_007F, 0, 0, "R9 wr");
    acc(1, 12'h800, 32'h5A5A_0000, 0, 0, "R9 wr");
    acc(1, 12'hBFC, 32'h5A5A_00FF, 0, 0, "R9 wr");
    acc(0, 12'h200, 0, 32'hA5A5_0001, 0, "R9 pal0");
    acc(0, 12'h204, 0, 32'hA5A5_0002, 0, "R9 pal1");
    acc(0, 12'h3FC, 0, 32'hA5A5_007F, 0, "R9 pal127");
    acc(0, 12'h800, 0, 32'h5A5A_0000, 0, "R9 cur0");
    acc(0, 12'hBFC, 0, 32'h5A5A_00FF, 0, "R9 cur255");
    acc(0, 12'h804, 0, 32'h0, 0, "R9 cur1");

    // R10 unmapped
    acc(0, 12'h400, 0, 0, 1, "R10 gap read");
    acc(1, 12'h400, 32'hDEAD_BEEF, 0, 1, "R10 gap write");
    acc(0, 12'h3FC, 0, 32'hA5A5_007F, 0, "R10 pal untouched");
    acc(0, 12'h202, 0, 0, 1, "R10 misaligned");
    acc(1, 12'h012, 32'hDEAD_BEEF, 0, 1, "R10 misaligned wr");
    acc(0, 12'h010, 0, 32'h8000_1000, 0, "R10 ubase untouched");
    acc(0, 12'h034, 0, 0, 1, "R10 past regs");
    acc(0, 12'hC00, 0, 0, 1, "R10 past cursor");

    @(negedge clk);
    @(negedge clk);
    if (sb.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule